// File: doc/BRIEF.md
# Teletext Character Rounding Pixel Generator

This block turns one text cell of a 40-column teletext-style display into twelve serial pixels. Each cell is started by a one-cycle strobe that carries the character code, the scan line inside the character row, the interlace field flag, the graphics-mode flag and the double-height state. The block works out which glyph row is on screen and which neighbouring row serves as a reference. It sends both addresses at once to an external two-port character ROM. From the two rows that come back it computes diagonal smoothing (character rounding) with a few gates, so the font is never stored in a pre-rounded double-resolution form.

Each 6-dot glyph row becomes 12 pixels, two per dot. The block adds a half-dot beside a set dot wherever the reference row carries a diagonal neighbour and both orthogonal neighbours are empty. Mosaic graphics cells are shifted out as raw doubled dots. The block runs on the pixel clock. The pixels are shifted out serially and are never resampled. Cells may be issued every 12 cycles to give an unbroken line.

Top module: `txt_round_gen`

## Requirements
- R1: While and after synchronous active-low reset, and before the first cell, `pix_act` and `pix_out` are 0.
- R2: One cycle after a `cell_go` cycle, `rom_cur_addr` equals {char_code, source row}. The code is in bits 10:4 and the row in bits 3:0. In normal height the source row equals `scan_line`.
- R3: In normal height, `field_odd`=1 selects the row below as reference (source row + 1) and `field_odd`=0 selects the row above (source row − 1). `rom_ref_addr` carries {char_code, reference row mod 16}.
- R4: A reference row outside 0..9 counts as a blank row, whatever the ROM returns for that address.
- R5: With `dh_on`=1 the source row is `scan_line`/2, plus 5 when `dh_lower`=1. An even `scan_line` selects the row above and an odd one selects the row below. `field_odd` is ignored.
- R6: The 12 pixels of a cell appear on `pix_out` while `pix_act`=1. The first pixel is visible two cycles after the `cell_go` cycle. The order is the leftmost dot first (ROM data bit 5), and the left half of each dot comes before its right half.
- R7: A set dot of the current row gives two lit pixels. A clear dot stays dark unless R8 lights one of its halves.
- R8: For a clear current dot j, its left half is lit when current dot j−1 and reference dot j are set and reference dot j−1 is clear. Its right half is lit when current dot j+1 and reference dot j are set and reference dot j+1 is clear. Columns outside 0..5 are clear.
- R9: A cell with `gfx_mode`=1 and `char_code` bit 5 = 1 is mosaic and gets no rounding. With `gfx_mode`=1 and bit 5 = 0 the cell is rounded as text.
- R10: Cells issued every 12 cycles give an unbroken run of `pix_act`. `pix_out` is 0 whenever `pix_act` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_go | input | 1 | Starts a cell, samples the cell inputs |
| char_code | input | 7 | Character code of the cell |
| gfx_mode | input | 1 | Graphics mode is active for this cell |
| scan_line | input | 4 | Scan line within the character row (0..9) |
| field_odd | input | 1 | Interlace field flag |
| dh_on | input | 1 | Double-height row |
| dh_lower | input | 1 | Lower half of a double-height row |
| rom_cur_addr | output | 11 | ROM address of the displayed row |
| rom_ref_addr | output | 11 | ROM address of the reference row |
| rom_data_cur | input | 6 | Dots of the displayed row, bit 5 leftmost |
| rom_data_ref | input | 6 | Dots of the reference row, bit 5 leftmost |
| pix_out | output | 1 | Serial pixel |
| pix_act | output | 1 | Pixel slot of a cell is being shown |

## Verification
In back-to-back operation the next cell's pattern is loaded in the same cycle that the last pixel of the previous cell is shown. Its ROM addresses change one cycle earlier, while the previous cell is still shifting. The bench provokes this by issuing cells exactly 12 cycles apart, with different codes, fields and height modes. The scoreboard checks every cell's 12 pixels against values computed from the rounding rule, and a run-length counter checks that `pix_act` never drops between cells.

// File: rtl/txt_round_pkg.sv
// Package: shared sizes and helper types for the rounding pixel generator.
// Assumes a 6-dot wide glyph and two output pixels per dot.
package txt_round_pkg;
    localparam int DOTS_PER_ROW = 6;
    localparam int PIX_PER_DOT  = 2;

    // Sampled context of one cell, held while its ROM rows are fetched
    typedef struct packed {
        logic [6:0] code;
        logic [3:0] cur_row;
        logic [3:0] ref_row;
        logic       ref_ok;
        logic       mosaic;
    } cell_ctx_t;
endpackage

// File: rtl/tr_row_sel.sv
// Row selector: on a cell strobe it registers the code, the displayed glyph row,
// the reference row and whether that reference lies inside the glyph.
// Assumes scan_line < GLYPH_ROWS, and GLYPH_ROWS is even for double height.
module tr_row_sel #(
    parameter int CODE_W     = 7,
    parameter int ROW_W      = 4,
    parameter int GLYPH_ROWS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_go,
    input  logic [CODE_W-1:0] char_code,
    input  logic              gfx_mode,
    input  logic [ROW_W-1:0]  scan_line,
    input  logic              field_odd,
    input  logic              dh_on,
    input  logic              dh_lower,
    output logic [CODE_W-1:0] code_q,
    output logic [ROW_W-1:0]  cur_row_q,
    output logic [ROW_W-1:0]  ref_row_q,
    output logic              ref_ok_q,
    output logic              mosaic_q,
    output logic              go_q
);
    localparam int HALF_ROWS = GLYPH_ROWS / 2;

    logic [ROW_W-1:0] src_row;
    logic [ROW_W-1:0] ref_row;
    logic             ref_ok;
    logic             below;

    // Work out the displayed row and its reference for the cell being strobed
    always_comb begin
        if (dh_on) begin
            src_row = (scan_line >> 1) + (dh_lower ? ROW_W'(HALF_ROWS) : ROW_W'(0));
            below   = scan_line[0];
        end else begin
            src_row = scan_line;
            below   = field_odd;
        end
        if (below) begin
            ref_row = src_row + ROW_W'(1);
            ref_ok  = ({1'b0, src_row} + (ROW_W+1)'(1)) < (ROW_W+1)'(GLYPH_ROWS);
        end else begin
            ref_row = src_row - ROW_W'(1);
            ref_ok  = (src_row != '0);
        end
    end

    // Hold the cell context until the next strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q    <= '0;
            cur_row_q <= '0;
            ref_row_q <= '0;
            ref_ok_q  <= 1'b0;
            mosaic_q  <= 1'b0;
        end else if (cell_go) begin
            code_q    <= char_code;
            cur_row_q <= src_row;
            ref_row_q <= ref_row;
            ref_ok_q  <= ref_ok;
            mosaic_q  <= gfx_mode & char_code[5];
        end
    end

    // Delayed strobe: ROM rows are valid in the cycle after the capture
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= cell_go;
    end
endmodule

// File: rtl/tr_smooth.sv
// Rounding gates: expands a current glyph row to two pixels per dot and adds
// half-dots from diagonal neighbours found in the reference row.
// Assumes bit DOT_W-1 is the leftmost dot; purely combinational.
module tr_smooth #(
    parameter int DOT_W = 6
) (
    input  logic               mosaic,
    input  logic               ref_ok,
    input  logic [DOT_W-1:0]   cur_dots,
    input  logic [DOT_W-1:0]   ref_dots,
    output logic [2*DOT_W-1:0] pattern
);
    logic [DOT_W+1:0] cp;
    logic [DOT_W+1:0] rp;

    // Pad both rows with a clear column on each side; blank an out-of-range reference
    always_comb begin
        cp = {1'b0, cur_dots, 1'b0};
        rp = {1'b0, (ref_ok ? ref_dots : '0), 1'b0};
    end

    for (genvar j = 0; j < DOT_W; j++) begin : g_col
        localparam int K = DOT_W - j;
        logic left_fill;
        logic right_fill;
        // Diagonal fill from the set dot on the left or on the right
        always_comb begin
            left_fill  = !mosaic && cp[K+1] && rp[K] && !rp[K+1];
            right_fill = !mosaic && cp[K-1] && rp[K] && !rp[K-1];
        end
        assign pattern[2*DOT_W-1-2*j] = cp[K] | left_fill;
        assign pattern[2*DOT_W-2-2*j] = cp[K] | right_fill;
    end
endmodule

// File: rtl/tr_shifter.sv
// Serializer: loads a cell pattern and shifts it out MSB first, one pixel per
// clock, flagging the active slots. Assumes loads arrive at least PIX_N apart.
module tr_shifter #(
    parameter int PIX_N = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PIX_N-1:0] pattern,
    output logic             pix_out,
    output logic             pix_act
);
    localparam int CNT_W = $clog2(PIX_N + 1);

    logic [PIX_N-1:0] sh;
    logic [CNT_W-1:0] left;

    // Load a new pattern or advance the current one by one pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            left <= '0;
        end else if (load) begin
            sh   <= pattern;
            left <= CNT_W'(PIX_N);
        end else if (left != '0) begin
            sh   <= sh << 1;
            left <= left - CNT_W'(1);
        end
    end

    assign pix_act = (left != '0);
    assign pix_out = pix_act & sh[PIX_N-1];
endmodule

// File: rtl/txt_round_gen.sv
// Top: teletext rounding pixel generator. Selects glyph and reference rows,
// reads both from an external two-port ROM, applies rounding and serializes.
// Assumes the ROM read is combinational (data valid in the address cycle).
module txt_round_gen #(
    parameter int CODE_W     = 7,
    parameter int ROW_W      = 4,
    parameter int GLYPH_ROWS = 10,
    parameter int DOT_W      = txt_round_pkg::DOTS_PER_ROW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cell_go,
    input  logic [CODE_W-1:0]       char_code,
    input  logic                    gfx_mode,
    input  logic [ROW_W-1:0]        scan_line,
    input  logic                    field_odd,
    input  logic                    dh_on,
    input  logic                    dh_lower,
    output logic [CODE_W+ROW_W-1:0] rom_cur_addr,
    output logic [CODE_W+ROW_W-1:0] rom_ref_addr,
    input  logic [DOT_W-1:0]        rom_data_cur,
    input  logic [DOT_W-1:0]        rom_data_ref,
    output logic                    pix_out,
    output logic                    pix_act
);
    localparam int PIX_N = DOT_W * txt_round_pkg::PIX_PER_DOT;

    logic [CODE_W-1:0] code_q;
    logic [ROW_W-1:0]  cur_row_q;
    logic [ROW_W-1:0]  ref_row_q;
    logic              ref_ok_q;
    logic              mosaic_q;
    logic              ld_go;
    logic [PIX_N-1:0]  pat_w;

    tr_row_sel #(
        .CODE_W(CODE_W), .ROW_W(ROW_W), .GLYPH_ROWS(GLYPH_ROWS)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .cell_go(cell_go), .char_code(char_code),
        .gfx_mode(gfx_mode), .scan_line(scan_line), .field_odd(field_odd),
        .dh_on(dh_on), .dh_lower(dh_lower), .code_q(code_q),
        .cur_row_q(cur_row_q), .ref_row_q(ref_row_q), .ref_ok_q(ref_ok_q),
        .mosaic_q(mosaic_q), .go_q(ld_go)
    );

    assign rom_cur_addr = {code_q, cur_row_q};
    assign rom_ref_addr = {code_q, ref_row_q};

    tr_smooth #(.DOT_W(DOT_W)) u_smooth (
        .mosaic(mosaic_q), .ref_ok(ref_ok_q), .cur_dots(rom_data_cur),
        .ref_dots(rom_data_ref), .pattern(pat_w)
    );

    tr_shifter #(.PIX_N(PIX_N)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(ld_go), .pattern(pat_w),
        .pix_out(pix_out), .pix_act(pix_act)
    );
endmodule

// File: rtl/tr_chk.sv
// Checker: timing, addressing and rounding properties of txt_round_gen.
module tr_chk #(
    parameter int CODE_W     = 7,
    parameter int ROW_W      = 4,
    parameter int GLYPH_ROWS = 10,
    parameter int DOT_W      = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cell_go,
    input logic [ROW_W-1:0]        scan_line,
    input logic                    field_odd,
    input logic                    dh_on,
    input logic                    dh_lower,
    input logic [CODE_W+ROW_W-1:0] rom_cur_addr,
    input logic [CODE_W+ROW_W-1:0] rom_ref_addr,
    input logic [DOT_W-1:0]        rom_data_cur,
    input logic                    ld_go,
    input logic [2*DOT_W-1:0]      pat_w,
    input logic                    pix_out,
    input logic                    pix_act
);
    logic [2*DOT_W-1:0] cur_dup;
    for (genvar j = 0; j < DOT_W; j++) begin : g_dup
        assign cur_dup[2*j]   = rom_data_cur[j];
        assign cur_dup[2*j+1] = rom_data_cur[j];
    end

    a_r10_dark_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_act |-> !pix_out);

    a_r6_first_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        cell_go |-> ##2 pix_act);

    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_go |=> ($stable(rom_cur_addr) && $stable(rom_ref_addr)));

    a_r3_ref_below: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_go && !dh_on && field_odd && (scan_line < ROW_W'(GLYPH_ROWS - 1)))
        |=> (rom_ref_addr[ROW_W-1:0] == rom_cur_addr[ROW_W-1:0] + ROW_W'(1)));

    a_r5_dh_upper_row: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_go && dh_on && !dh_lower)
        |=> (rom_cur_addr[ROW_W-1:0] == ($past(scan_line) >> 1)));

    a_r7_dots_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |-> ((pat_w & cur_dup) == cur_dup));
endmodule

bind txt_round_gen tr_chk #(
    .CODE_W(CODE_W), .ROW_W(ROW_W), .GLYPH_ROWS(GLYPH_ROWS), .DOT_W(DOT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cell_go(cell_go), .scan_line(scan_line),
    .field_odd(field_odd), .dh_on(dh_on), .dh_lower(dh_lower),
    .rom_cur_addr(rom_cur_addr), .rom_ref_addr(rom_ref_addr),
    .rom_data_cur(rom_data_cur), .ld_go(ld_go), .pat_w(pat_w),
    .pix_out(pix_out), .pix_act(pix_act)
);

// File: tb/sim_txt_round_gen.sv
module sim_txt_round_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cell_go = 1'b0;
    logic [6:0]  char_code = '0;
    logic        gfx_mode = 1'b0;
    logic [3:0]  scan_line = '0;
    logic        field_odd = 1'b0;
    logic        dh_on = 1'b0;
    logic        dh_lower = 1'b0;
    logic [10:0] rom_cur_addr, rom_ref_addr;
    logic [5:0]  rom_data_cur, rom_data_ref;
    logic        pix_out, pix_act;

    int checks = 0;
    int bad = 0;
    int cycles = 0;
    int run = 0;
    int max_run = 0;
    logic [11:0] exp_q[$];
    string       tag_q[$];
    logic [11:0] got_sh = '0;
    int          got_n = 0;

    always #10 clk = ~clk;

    txt_round_gen u0 (
        .clk(clk), .rst_n(rst_n), .cell_go(cell_go), .char_code(char_code),
        .gfx_mode(gfx_mode), .scan_line(scan_line), .field_odd(field_odd),
        .dh_on(dh_on), .dh_lower(dh_lower), .rom_cur_addr(rom_cur_addr),
        .rom_ref_addr(rom_ref_addr), .rom_data_cur(rom_data_cur),
        .rom_data_ref(rom_data_ref), .pix_out(pix_out), .pix_act(pix_act)
    );

    // Bench font: codes with low bits 00001 form a diagonal, others a hash
    function automatic logic [5:0] glyph(input logic [6:0] c, input int r);
        int h;
        if (c[4:0] == 5'd1) return 6'b100000 >> (r % 6);
        h = (int'(c) * 7 + r * 13) ^ (int'(c) * r) ^ 'h5A;
        return h[5:0];
    endfunction

    assign rom_data_cur = glyph(rom_cur_addr[10:4], int'(rom_cur_addr[3:0]));
    assign rom_data_ref = glyph(rom_ref_addr[10:4], int'(rom_ref_addr[3:0]));

    function automatic logic dot(input logic [5:0] v, input int j);
        if (j < 0 || j > 5) return 1'b0;
        return v[5-j];
    endfunction

    function automatic int src_of(input int sc, input logic dh, input logic lo);
        return dh ? (sc / 2 + (lo ? 5 : 0)) : sc;
    endfunction

    function automatic int ref_of(input int sc, input logic fo, input logic dh, input logic lo);
        logic below;
        below = dh ? sc[0] : fo;
        return below ? src_of(sc, dh, lo) + 1 : src_of(sc, dh, lo) - 1;
    endfunction

    // Expected 12 pixels from the requirement rules (R4, R7, R8, R9)
    function automatic logic [11:0] exp_pat(input logic [6:0] c, input int sc,
        input logic fo, input logic gm, input logic dh, input logic lo);
        logic [5:0] cu, rf;
        logic [11:0] p;
        int s, r;
        logic mos;
        s = src_of(sc, dh, lo);
        r = ref_of(sc, fo, dh, lo);
        cu = glyph(c, s);
        rf = (r >= 0 && r <= 9) ? glyph(c, r) : 6'b0;
        mos = gm && c[5];
        for (int j = 0; j < 6; j++) begin
            p[11-2*j] = dot(cu, j) | (!mos && dot(cu, j-1) && dot(rf, j) && !dot(rf, j-1));
            p[10-2*j] = dot(cu, j) | (!mos && dot(cu, j+1) && dot(rf, j) && !dot(rf, j+1));
        end
        return p;
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Driver: push expectation, strobe one cell, check its addresses, fill 12 cycles
    task automatic put_cell(input logic [6:0] c, input int sc, input logic fo,
        input logic gm, input logic dh, input logic lo, input logic [11:0] e, input string tag);
        int s, r;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        char_code = c; scan_line = 4'(sc); field_odd = fo;
        gfx_mode = gm; dh_on = dh; dh_lower = lo; cell_go = 1'b1;
        @(negedge clk);
        cell_go = 1'b0;
        s = src_of(sc, dh, lo);
        r = ref_of(sc, fo, dh, lo);
        check(rom_cur_addr == {c, 4'(s)}, "R2/R5 cur addr", int'(rom_cur_addr), int'({c, 4'(s)}));
        check(rom_ref_addr == {c, 4'(r)}, "R3/R5 ref addr", int'(rom_ref_addr), int'({c, 4'(r)}));
        repeat (11) @(negedge clk);
    endtask

    // Monitor: collect pixels of each active run and compare with the queue
    always @(negedge clk) begin
        if (rst_n) begin
            run = pix_act ? run + 1 : 0;
            if (run > max_run) max_run = run;
            if (!pix_act && pix_out) check(1'b0, "R10 pixel while idle", 1, 0);
            if (pix_act) begin
                got_sh = {got_sh[10:0], pix_out};
                got_n++;
                if (got_n == 12) begin
                    got_n = 0;
                    if (exp_q.size() == 0) check(1'b0, "R6 unexpected cell", int'(got_sh), 0);
                    else begin
                        logic [11:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(got_sh == e, t, int'(got_sh), int'(e));
                    end
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("test done: total=%0d bad=%0d", checks + 1, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!pix_act && !pix_out, "R1 in reset", int'({pix_act, pix_out}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!pix_act && !pix_out, "R1 after reset", int'({pix_act, pix_out}), 0);

        // R6 latency: first pixel two cycles after the strobe
        exp_q.push_back(12'h0E0); tag_q.push_back("R8 below diag");
        char_code = 7'h41; scan_line = 4'd2; field_odd = 1'b1;
        gfx_mode = 1'b0; dh_on = 1'b0; dh_lower = 1'b0; cell_go = 1'b1;
        @(negedge clk); cell_go = 1'b0;
        check(!pix_act, "R6 not yet active", int'(pix_act), 0);
        @(negedge clk);
        check(pix_act, "R6 active second cycle", int'(pix_act), 1);
        repeat (14) @(negedge clk);

        put_cell(7'h41, 2, 1'b0, 1'b0, 1'b0, 1'b0, 12'h1C0, "R8 above diag");
        put_cell(7'h41, 9, 1'b1, 1'b0, 1'b0, 1'b0, 12'h030, "R4 ref beyond glyph");
        put_cell(7'h61, 2, 1'b1, 1'b1, 1'b0, 1'b0, 12'h0C0, "R9 mosaic unrounded");
        put_cell(7'h41, 2, 1'b1, 1'b1, 1'b0, 1'b0, 12'h0E0, "R9 gfx alpha rounded");
        put_cell(7'h41, 5, 1'b0, 1'b0, 1'b1, 1'b0, 12'h0E0, "R5 dh odd below");
        put_cell(7'h41, 4, 1'b1, 1'b0, 1'b1, 1'b0, 12'h1C0, "R5 dh even above");
        put_cell(7'h41, 4, 1'b0, 1'b0, 1'b1, 1'b1, 12'h700, "R5 dh lower");
        repeat (4) @(negedge clk);

        // R10 back-to-back stream over mixed cells, R7/R8 with the hash font
        max_run = 0;
        for (int k = 0; k < 24; k++) begin
            logic [6:0] c;
            int sc;
            logic fo, gm, dh, lo;
            c = 7'((k * 29 + 5) % 128);
            sc = (k * 3) % 10;
            fo = k[0]; gm = k[2]; dh = (k % 5 == 3); lo = k[1];
            put_cell(c, sc, fo, gm, dh, lo, exp_pat(c, sc, fo, gm, dh, lo), "R7/R8 stream");
        end
        repeat (4) @(negedge clk);
        check(max_run >= 24 * 12, "R10 unbroken run", max_run, 24 * 12);
        check(exp_q.size() == 0, "R6 all cells shown", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule